// File: doc/BRIEF.md
# Output Frequency Source Selector

This block decides which frequency setting the clock synthesizer follows, and it flags each moment that setting moves. Five strap inputs are sampled once, just after reset is released. They are held as read-only bits until the next reset. The setting can come from those straps, from a 5-bit code that software writes, or from a direct numerator/denominator pair (N, M) when programmable mode is on. In programmable mode the 5-bit code still sets the gear constant and the ratios between clock groups. The synthesizer itself takes the pair, so the block presents N+3 and M+3.

A watchdog timeout moves the block into recovery, and it stays there until reset. In recovery the setting falls back either to the latched straps or to a separate recovery N/M pair, as a select bit chooses. A divider pair whose ratio is not above one is refused: an invalid flag goes up and the last good pair stays on the outputs. A single-cycle strobe marks every change of the effective setting, and every change in value of any N or M register, whether or not that register is in use at the time.

Top module: `freq_src_sel`

## Requirements
- R1: The straps are captured on the first clock edge after reset is released and appear on `strap_latched`. Later changes of `strap_in` affect neither `strap_latched` nor `active_code` until the next reset.
- R2: When programmable mode is off, recovery is inactive and the override bit is 0, `active_code` equals the latched straps. In this case `div_num`, `div_den` and `ratio_bad` are 0.
- R3: When programmable mode is off, recovery is inactive and the override bit is 1, `active_code` equals `sw_code`. The divider outputs are 0.
- R4: With programmable mode on and a valid ratio, `div_num` = N+3 and `div_den` = M+3. `active_code` still follows the override bit: 1 selects `sw_code`, 0 selects the straps.
- R5: A pair in use with N+3 <= M+3 sets `ratio_bad` to 1. While that pair is in use, `div_num` and `div_den` keep the last valid pair.
- R6: A high `wdt_timeout` puts the block into recovery, and recovery lasts until reset. With `rcv_sel` = 0 during recovery, `active_code` is the latched straps and the divider outputs are 0, whatever `prog_en` and `ovr` are.
- R7: With `rcv_sel` = 1 during recovery, the divider outputs come from `rcv_n`+3 and `rcv_m`+3, under the same validity rule as R5. `active_code` follows the override bit.
- R8: `freq_chg` is high for one cycle after any clock edge at which `active_code`, `div_num`, `div_den` or `ratio_bad` changes, or at which any of `prog_n`, `prog_m`, `rcv_n`, `rcv_m` differs from its value one cycle earlier. It stays low when none of these changes, including on the capture edge right after reset.
- R9: While reset is low, every output is 0.
- R10: All outputs are registered. An input change in the cycle before clock edge k shows at the outputs just after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_in | input | 5 | Strap pins, sampled once after reset |
| sw_code | input | 5 | Software ratio code |
| ovr | input | 1 | Override: 1 selects sw_code over the straps |
| prog_en | input | 1 | Programmable N/M mode enable |
| prog_n | input | 8 | Programmable N value |
| prog_m | input | 7 | Programmable M value |
| rcv_sel | input | 1 | Recovery source: 0 straps, 1 recovery N/M |
| rcv_n | input | 8 | Recovery N value |
| rcv_m | input | 7 | Recovery M value |
| wdt_timeout | input | 1 | Watchdog timeout indication |
| strap_latched | output | 5 | Captured straps (read-only) |
| active_code | output | 5 | Active 5-bit ratio code |
| div_num | output | 9 | Divider numerator N+3, 0 in code mode |
| div_den | output | 8 | Divider denominator M+3, 0 in code mode |
| ratio_bad | output | 1 | Pair in use has a ratio not above one |
| freq_chg | output | 1 | One-cycle frequency-change strobe |

## Verification
A wrong source choice appears on `active_code` or the divider outputs on the edge right after the inputs move. A spurious or missing strobe appears on `freq_chg` in that same cycle. A recovery flag that clears when it should not returns the outputs to `prog_n` or `sw_code` values as soon as software changes them. A held pair that does not hold shows a ratio at or below one on the divider outputs. That last fault is visible in the very cycle an invalid pair is offered.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  parameter int CODE_W = 5;
  parameter int N_W    = 8;
  parameter int M_W    = 7;
  parameter int NM_OFS = 3;
  localparam int NUM_W = N_W + 1;
  localparam int DEN_W = M_W + 1;

  typedef enum logic [1:0] {
    SRC_CODE      = 2'd0,
    SRC_PROG      = 2'd1,
    SRC_RCV_NM    = 2'd2,
    SRC_RCV_STRAP = 2'd3
  } src_e;

  function automatic logic [NUM_W-1:0] num_of(input logic [N_W-1:0] n);
    return NUM_W'(n) + NUM_W'(NM_OFS);
  endfunction

  function automatic logic [DEN_W-1:0] den_of(input logic [M_W-1:0] m);
    return DEN_W'(m) + DEN_W'(NM_OFS);
  endfunction

  function automatic logic ratio_ok(input logic [NUM_W-1:0] num,
                                    input logic [DEN_W-1:0] den);
    return num > NUM_W'(den);
  endfunction
endpackage

// File: rtl/fsel_strap.sv
module fsel_strap
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_in,
  output logic [CODE_W-1:0] strap_q,
  output logic [CODE_W-1:0] strap_eff,
  output logic              cap_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= '0;
      cap_done <= 1'b0;
    end else if (!cap_done) begin
      strap_q  <= strap_in;
      cap_done <= 1'b1;
    end
  end

  // before capture completes, the value about to be captured is used
  assign strap_eff = cap_done ? strap_q : strap_in;
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
  import fsel_pkg::*;
(
  input  logic [CODE_W-1:0] strap_eff,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              ovr,
  input  logic              prog_en,
  input  logic              rcv_now,
  input  logic              rcv_sel,
  input  logic [N_W-1:0]    prog_n,
  input  logic [M_W-1:0]    prog_m,
  input  logic [N_W-1:0]    rcv_n,
  input  logic [M_W-1:0]    rcv_m,
  input  logic [NUM_W-1:0]  held_num,
  input  logic [DEN_W-1:0]  held_den,
  output src_e              src,
  output logic [CODE_W-1:0] code_nx,
  output logic [NUM_W-1:0]  cand_num,
  output logic [DEN_W-1:0]  cand_den,
  output logic              hold_load,
  output logic [NUM_W-1:0]  num_nx,
  output logic [DEN_W-1:0]  den_nx,
  output logic              bad_nx
);
  logic use_nm;
  logic cand_ok;

  always_comb begin
    if (rcv_now) src = rcv_sel ? SRC_RCV_NM : SRC_RCV_STRAP;
    else         src = prog_en ? SRC_PROG : SRC_CODE;
  end

  assign code_nx  = (src == SRC_RCV_STRAP) ? strap_eff
                  : (ovr ? sw_code : strap_eff);
  assign cand_num = (src == SRC_RCV_NM) ? num_of(rcv_n) : num_of(prog_n);
  assign cand_den = (src == SRC_RCV_NM) ? den_of(rcv_m) : den_of(prog_m);
  assign use_nm   = (src == SRC_PROG) || (src == SRC_RCV_NM);
  assign cand_ok  = ratio_ok(cand_num, cand_den);

  assign hold_load = use_nm && cand_ok;
  assign num_nx    = !use_nm ? '0 : (cand_ok ? cand_num : held_num);
  assign den_nx    = !use_nm ? '0 : (cand_ok ? cand_den : held_den);
  assign bad_nx    = use_nm && !cand_ok;
endmodule

// File: rtl/fsel_chg.sv
module fsel_chg
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_done,
  input  logic [N_W-1:0]    prog_n,
  input  logic [M_W-1:0]    prog_m,
  input  logic [N_W-1:0]    rcv_n,
  input  logic [M_W-1:0]    rcv_m,
  input  logic [CODE_W-1:0] code_nx,
  input  logic [NUM_W-1:0]  num_nx,
  input  logic [DEN_W-1:0]  den_nx,
  input  logic              bad_nx,
  input  logic [CODE_W-1:0] code_q,
  input  logic [NUM_W-1:0]  num_q,
  input  logic [DEN_W-1:0]  den_q,
  input  logic              bad_q,
  output logic              nm_moved,
  output logic              out_moved,
  output logic              chg_nx
);
  logic [N_W-1:0] pn_q, rn_q;
  logic [M_W-1:0] pm_q, rm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pn_q <= '0;
      pm_q <= '0;
      rn_q <= '0;
      rm_q <= '0;
    end else begin
      pn_q <= prog_n;
      pm_q <= prog_m;
      rn_q <= rcv_n;
      rm_q <= rcv_m;
    end
  end

  assign nm_moved  = (prog_n != pn_q) || (prog_m != pm_q)
                  || (rcv_n  != rn_q) || (rcv_m  != rm_q);
  assign out_moved = (code_nx != code_q) || (num_nx != num_q)
                  || (den_nx  != den_q)  || (bad_nx != bad_q);
  // the capture edge only primes the history registers
  assign chg_nx    = cap_done && (nm_moved || out_moved);
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_in,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              ovr,
  input  logic              prog_en,
  input  logic [N_W-1:0]    prog_n,
  input  logic [M_W-1:0]    prog_m,
  input  logic              rcv_sel,
  input  logic [N_W-1:0]    rcv_n,
  input  logic [M_W-1:0]    rcv_m,
  input  logic              wdt_timeout,
  output logic [CODE_W-1:0] strap_latched,
  output logic [CODE_W-1:0] active_code,
  output logic [NUM_W-1:0]  div_num,
  output logic [DEN_W-1:0]  div_den,
  output logic              ratio_bad,
  output logic              freq_chg
);
  logic [CODE_W-1:0] strap_q, strap_eff, code_nx, code_q;
  logic              cap_done;
  logic              rcv_q, rcv_now;
  src_e              src;
  logic [NUM_W-1:0]  cand_num, num_nx, num_q, held_num;
  logic [DEN_W-1:0]  cand_den, den_nx, den_q, held_den;
  logic              hold_load, bad_nx, bad_q;
  logic              nm_moved, out_moved, chg_nx, chg_q;

  fsel_strap u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
    .strap_q(strap_q), .strap_eff(strap_eff), .cap_done(cap_done)
  );

  // recovery is sticky until reset
  assign rcv_now = rcv_q || wdt_timeout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcv_q <= 1'b0;
    else        rcv_q <= rcv_now;
  end

  fsel_mux u_mux (
    .strap_eff(strap_eff), .sw_code(sw_code), .ovr(ovr), .prog_en(prog_en),
    .rcv_now(rcv_now), .rcv_sel(rcv_sel),
    .prog_n(prog_n), .prog_m(prog_m), .rcv_n(rcv_n), .rcv_m(rcv_m),
    .held_num(held_num), .held_den(held_den),
    .src(src), .code_nx(code_nx), .cand_num(cand_num), .cand_den(cand_den),
    .hold_load(hold_load), .num_nx(num_nx), .den_nx(den_nx), .bad_nx(bad_nx)
  );

  fsel_chg u_chg (
    .clk(clk), .rst_n(rst_n), .cap_done(cap_done),
    .prog_n(prog_n), .prog_m(prog_m), .rcv_n(rcv_n), .rcv_m(rcv_m),
    .code_nx(code_nx), .num_nx(num_nx), .den_nx(den_nx), .bad_nx(bad_nx),
    .code_q(code_q), .num_q(num_q), .den_q(den_q), .bad_q(bad_q),
    .nm_moved(nm_moved), .out_moved(out_moved), .chg_nx(chg_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_num <= '0;
      held_den <= '0;
    end else if (hold_load) begin
      held_num <= cand_num;
      held_den <= cand_den;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      num_q  <= '0;
      den_q  <= '0;
      bad_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_nx;
      num_q  <= num_nx;
      den_q  <= den_nx;
      bad_q  <= bad_nx;
      chg_q  <= chg_nx;
    end
  end

  assign strap_latched = strap_q;
  assign active_code   = code_q;
  assign div_num       = num_q;
  assign div_den       = den_q;
  assign ratio_bad     = bad_q;
  assign freq_chg      = chg_q;
endmodule

// File: rtl/fsel_chk.sv
module fsel_chk
  import fsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_done,
  input logic              rcv_q,
  input logic              rcv_sel,
  input logic [CODE_W-1:0] strap_latched,
  input logic [CODE_W-1:0] active_code,
  input logic [NUM_W-1:0]  div_num,
  input logic [DEN_W-1:0]  div_den,
  input logic              freq_chg
);
  // R1: once captured, the straps never move
  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_done) |-> $stable(strap_latched));

  // R5: any nonzero pair on the outputs has a ratio above one
  p_ratio_gt_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_num != '0) |-> (div_num > NUM_W'(div_den)));

  // R6: recovery is sticky
  p_rcv_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_q |=> rcv_q);

  // R6: recovery from straps forces strap code and no divider pair
  p_rcv_strap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_q && !$past(rcv_sel)) |-> (active_code == strap_latched && div_num == '0));

  // R8: a code change after capture is always strobed
  p_code_strobed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_done) && active_code != $past(active_code)) |-> freq_chg);
endmodule

bind freq_src_sel fsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_done(cap_done), .rcv_q(rcv_q),
  .rcv_sel(rcv_sel), .strap_latched(strap_latched), .active_code(active_code),
  .div_num(div_num), .div_den(div_den), .freq_chg(freq_chg)
);

// File: tb/freq_src_sel_tb.sv
module freq_src_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] strap_in = 5'd22;
  logic [4:0] sw_code = '0;
  logic       ovr = 1'b0, prog_en = 1'b0, rcv_sel = 1'b0, wdt_timeout = 1'b0;
  logic [7:0] prog_n = '0, rcv_n = '0;
  logic [6:0] prog_m = '0, rcv_m = '0;
  logic [4:0] strap_latched, active_code;
  logic [8:0] div_num;
  logic [7:0] div_den;
  logic       ratio_bad, freq_chg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  freq_src_sel u_dut (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .sw_code(sw_code),
    .ovr(ovr), .prog_en(prog_en), .prog_n(prog_n), .prog_m(prog_m),
    .rcv_sel(rcv_sel), .rcv_n(rcv_n), .rcv_m(rcv_m), .wdt_timeout(wdt_timeout),
    .strap_latched(strap_latched), .active_code(active_code),
    .div_num(div_num), .div_den(div_den), .ratio_bad(ratio_bad), .freq_chg(freq_chg)
  );

  typedef struct packed {
    logic       pe;
    logic       ov;
    logic [4:0] sw;
    logic [7:0] n;
    logic [6:0] m;
    logic [4:0] ecode;
    logic [8:0] enm;
    logic [7:0] eden;
    logic       ebad;
    logic       echg;
  } vec_t;

  // straps are 22; recovery values stay 0 throughout the table
  localparam vec_t VECS [12] = '{
    {1'b0,1'b0,5'd3,8'd0,  7'd0,   5'd22,9'd0,  8'd0,  1'b0,1'b0}, // R2 unused sw change
    {1'b0,1'b1,5'd3,8'd0,  7'd0,   5'd3, 9'd0,  8'd0,  1'b0,1'b1}, // R3
    {1'b0,1'b1,5'd3,8'd100,7'd0,   5'd3, 9'd0,  8'd0,  1'b0,1'b1}, // R8 N write
    {1'b0,1'b1,5'd3,8'd100,7'd0,   5'd3, 9'd0,  8'd0,  1'b0,1'b0}, // R8 quiet
    {1'b1,1'b1,5'd3,8'd100,7'd50,  5'd3, 9'd103,8'd53, 1'b0,1'b1}, // R4
    {1'b1,1'b0,5'd3,8'd100,7'd50,  5'd22,9'd103,8'd53, 1'b0,1'b1}, // R4 ovr 0
    {1'b1,1'b0,5'd3,8'd10, 7'd50,  5'd22,9'd103,8'd53, 1'b1,1'b1}, // R5 below
    {1'b1,1'b0,5'd3,8'd50, 7'd50,  5'd22,9'd103,8'd53, 1'b1,1'b1}, // R5 equal
    {1'b1,1'b0,5'd3,8'd51, 7'd50,  5'd22,9'd54, 8'd53, 1'b0,1'b1}, // R5 just above
    {1'b1,1'b0,5'd3,8'd255,7'd127, 5'd22,9'd258,8'd130,1'b0,1'b1}, // R4 max
    {1'b1,1'b0,5'd3,8'd255,7'd127, 5'd22,9'd258,8'd130,1'b0,1'b0}, // R8 quiet
    {1'b0,1'b0,5'd3,8'd255,7'd127, 5'd22,9'd0,  8'd0,  1'b0,1'b1}  // R2 back
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(input string tag, input logic [4:0] c, input logic [8:0] nm,
                         input logic [7:0] dn, input logic b, input logic g);
    chk({tag, " code"}, 16'(active_code), 16'(c));
    chk({tag, " num"},  16'(div_num),     16'(nm));
    chk({tag, " den"},  16'(div_den),     16'(dn));
    chk({tag, " bad"},  16'(ratio_bad),   16'(b));
    chk({tag, " chg"},  16'(freq_chg),    16'(g));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    chk_all("R9 reset", 5'd0, 9'd0, 8'd0, 1'b0, 1'b0);
    chk("R9 strap", 16'(strap_latched), 16'd0);
    rst_n = 1'b1;
    step();
    // R1 capture, R8 no strobe on capture edge, R10 one-edge latency
    chk("R1 capture", 16'(strap_latched), 16'd22);
    chk_all("R8 first edge", 5'd22, 9'd0, 8'd0, 1'b0, 1'b0);

    foreach (VECS[i]) begin
      prog_en = VECS[i].pe;
      ovr     = VECS[i].ov;
      sw_code = VECS[i].sw;
      prog_n  = VECS[i].n;
      prog_m  = VECS[i].m;
      step();
      chk_all($sformatf("R10 vec%0d", i), VECS[i].ecode, VECS[i].enm,
              VECS[i].eden, VECS[i].ebad, VECS[i].echg);
    end

    // R1: strap pins moving after capture are ignored
    strap_in = 5'd9;
    step();
    chk("R1 strap hold", 16'(strap_latched), 16'd22);
    chk_all("R1 no effect", 5'd22, 9'd0, 8'd0, 1'b0, 1'b0);

    // R8: unused recovery registers still strobe
    rcv_n = 8'd200;
    rcv_m = 7'd10;
    step();
    chk_all("R8 rcv write", 5'd22, 9'd0, 8'd0, 1'b0, 1'b1);

    prog_en = 1'b1; ovr = 1'b1; sw_code = 5'd7; prog_n = 8'd100; prog_m = 7'd50;
    step();
    chk_all("R4 prog", 5'd7, 9'd103, 8'd53, 1'b0, 1'b1);

    // R6: timeout, recovery from straps
    wdt_timeout = 1'b1; rcv_sel = 1'b0;
    step();
    wdt_timeout = 1'b0;
    chk_all("R6 timeout", 5'd22, 9'd0, 8'd0, 1'b0, 1'b1);

    prog_en = 1'b0; ovr = 1'b0;
    step();
    chk_all("R6 sticky", 5'd22, 9'd0, 8'd0, 1'b0, 1'b0);

    // R7: recovery from N/M, code follows override
    rcv_sel = 1'b1; ovr = 1'b1;
    step();
    chk_all("R7 rcv nm", 5'd7, 9'd203, 8'd13, 1'b0, 1'b1);

    // R5 via R7: invalid recovery pair holds last good pair
    rcv_n = 8'd5;
    step();
    chk_all("R7 invalid", 5'd7, 9'd203, 8'd13, 1'b1, 1'b1);

    // R9 second reset, then R1 fresh capture and recovery cleared
    rst_n = 1'b0; ovr = 1'b0;
    @(negedge clk);
    chk_all("R9 reset2", 5'd0, 9'd0, 8'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step();
    chk("R1 recapture", 16'(strap_latched), 16'd9);
    chk_all("R6 cleared by reset", 5'd9, 9'd0, 8'd0, 1'b0, 1'b0);

    finish_run();
  end
endmodule